// File: doc/BRIEF.md
# Auto-Reload Up-Counting Timer

A register-mapped timer: one up-counter, as wide as the data bus, advances by one on every cycle in which its run bit is set and the `tick` input is high. When it passes the all-ones value it either reloads from a separate preload register and keeps running, or wraps to zero and stops itself. In both cases it raises a sticky overflow flag. Software clears that flag by writing a one to it. The interrupt line is the flag gated by an overflow enable bit.

Software programs the period through the preload register. With auto-reload on, a preload of all-ones minus (N-1) produces an overflow every N ticks. A preload of zero lets the counter run freely over its full range. A build parameter picks one of two register address layouts. The block has no stream traffic: the bus is a plain strobe interface with no back-pressure. Each write completes in its own cycle. Read data is combinational from the address while the read strobe is high.

Top module: `artimer_top`

## Requirements
- R1: After reset, all registers read as zero and `irq` is low. The counter holds still until software starts it.
- R2: While control bit 0 (run) is set, the counter increases by exactly one in every cycle with `tick` high. With `tick` low or run clear, it holds its value.
- R3: When a tick arrives with the counter at all-ones and control bit 1 (auto-reload) set, the next value is the preload register and run stays set. A preload of zero therefore wraps to 0 and keeps counting.
- R4: When a tick arrives at all-ones with auto-reload clear, the counter becomes 0 and the run bit clears, so later ticks have no effect.
- R5: Status bit 1 (overflow) is set by every overflow event of R3/R4. Writing a 1 to status bit 1 clears it, and writing 0 leaves it unchanged. If an overflow occurs in the same cycle as a clear, the flag ends up set.
- R6: `irq` is high exactly when the overflow flag and enable bit 1 are both set. Enable bits 0 and 2 are stored and read back but never raise `irq`.
- R7: A bus write to the counter in the same cycle as a tick loads the written value and discards the tick. A tick at all-ones in that cycle causes no overflow.
- R8: With auto-reload on and preload P = all-ones minus (N-1), the overflow flag sets after exactly N ticks from the counter holding P, and again after every further N ticks.
- R9: With LAYOUT=0, the offsets are status 0x28, enable 0x2C, control 0x38, counter 0x3C and preload 0x40. With LAYOUT=1, they are status 0x18, enable 0x1C, control 0x24, counter 0x28 and preload 0x2C. Any other address reads zero and ignores writes.
- R10: Control reads back in bits [1:0], enable in bits [2:0] and status in bit 1, with all other bits zero. While the read strobe is low, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable qualifier, one count per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, zero when no read |
| irq | output | 1 | Level interrupt, overflow flag AND overflow enable |

## Verification
The bench builds two copies side by side: one with LAYOUT=0 and one with LAYOUT=1. Both are driven by the same strobes, address and data. An offset such as 0x28 is the status register in one layout and the counter in the other, and 0x2C is the enable register in one and the preload in the other. Every access therefore also drives a different register, or no register, in the sibling copy. A behavioural model tracks both copies each cycle, so aliasing and decode mistakes show up directly. Directed phases drive the wrap point, the single-shot stop and the same-cycle write/tick and set/clear collisions.

// File: rtl/artimer_pkg.sv
`timescale 1ns/1ps
package artimer_pkg;
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_STS  = 3'd1,
    SEL_IEN  = 3'd2,
    SEL_CTL  = 3'd3,
    SEL_CNT  = 3'd4,
    SEL_LOAD = 3'd5
  } reg_sel_e;

  localparam int CTL_RUN   = 0;
  localparam int CTL_AUTO  = 1;
  localparam int IEN_MATCH = 0;
  localparam int IEN_OVF   = 1;
  localparam int IEN_CAPT  = 2;
  localparam int IEN_W     = 3;
  localparam int STS_OVF   = 1;
endpackage

// File: rtl/artimer_decode.sv
`timescale 1ns/1ps
module artimer_decode #(
  parameter int LAYOUT = 0,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]      addr,
  output artimer_pkg::reg_sel_e  sel
);
  import artimer_pkg::*;

  generate
    if (LAYOUT == 0) begin : g_map_high
      always_comb begin
        case (addr)
          ADDR_W'(8'h28): sel = SEL_STS;
          ADDR_W'(8'h2C): sel = SEL_IEN;
          ADDR_W'(8'h38): sel = SEL_CTL;
          ADDR_W'(8'h3C): sel = SEL_CNT;
          ADDR_W'(8'h40): sel = SEL_LOAD;
          default:        sel = SEL_NONE;
        endcase
      end
    end else begin : g_map_low
      always_comb begin
        case (addr)
          ADDR_W'(8'h18): sel = SEL_STS;
          ADDR_W'(8'h1C): sel = SEL_IEN;
          ADDR_W'(8'h24): sel = SEL_CTL;
          ADDR_W'(8'h28): sel = SEL_CNT;
          ADDR_W'(8'h2C): sel = SEL_LOAD;
          default:        sel = SEL_NONE;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/artimer_count.sv
`timescale 1ns/1ps
module artimer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_ctl,
  input  logic             wr_load,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] load_q,
  output logic             run_q,
  output logic             auto_q,
  output logic             wrap
);
  import artimer_pkg::*;

  logic advance;
  logic at_top;

  assign advance = run_q & tick;
  assign at_top  = &cnt_q;
  // a bus write to the counter swallows the tick, including its overflow
  assign wrap    = advance & at_top & ~wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      run_q  <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata;

      if (wr_cnt)       cnt_q <= wdata;
      else if (advance) cnt_q <= at_top ? (auto_q ? load_q : '0) : cnt_q + 1'b1;

      if (wr_ctl) begin
        run_q  <= wdata[CTL_RUN];
        auto_q <= wdata[CTL_AUTO];
      end else if (wrap && !auto_q) begin
        run_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/artimer_irqctl.sv
`timescale 1ns/1ps
module artimer_irqctl #(
  parameter int EN_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrap,
  input  logic            wr_sts,
  input  logic            clr_bit,
  input  logic            wr_ien,
  input  logic [EN_W-1:0] ien_wdata,
  output logic            ovf_q,
  output logic [EN_W-1:0] ien_q,
  output logic            irq
);
  import artimer_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      ien_q <= '0;
    end else begin
      if (wrap)                   ovf_q <= 1'b1;
      else if (wr_sts && clr_bit) ovf_q <= 1'b0;
      if (wr_ien) ien_q <= ien_wdata;
    end
  end

  assign irq = ovf_q & ien_q[IEN_OVF];
endmodule

// File: rtl/artimer_top.sv
`timescale 1ns/1ps
module artimer_top #(
  parameter int LAYOUT = 0,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import artimer_pkg::*;

  reg_sel_e          sel;
  logic              wr_cnt, wr_ctl, wr_load, wr_sts, wr_ien;
  logic [DATA_W-1:0] cnt_q, load_q;
  logic              run_q, auto_q, wrap, ovf_q;
  logic [IEN_W-1:0]  ien_q;

  artimer_decode #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_cnt  = bus_wr && (sel == SEL_CNT);
  assign wr_ctl  = bus_wr && (sel == SEL_CTL);
  assign wr_load = bus_wr && (sel == SEL_LOAD);
  assign wr_sts  = bus_wr && (sel == SEL_STS);
  assign wr_ien  = bus_wr && (sel == SEL_IEN);

  artimer_count #(.CNT_W(DATA_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_cnt  (wr_cnt),
    .wr_ctl  (wr_ctl),
    .wr_load (wr_load),
    .wdata   (bus_wdata),
    .cnt_q   (cnt_q),
    .load_q  (load_q),
    .run_q   (run_q),
    .auto_q  (auto_q),
    .wrap    (wrap)
  );

  artimer_irqctl #(.EN_W(IEN_W)) u_irqctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap      (wrap),
    .wr_sts    (wr_sts),
    .clr_bit   (bus_wdata[STS_OVF]),
    .wr_ien    (wr_ien),
    .ien_wdata (bus_wdata[IEN_W-1:0]),
    .ovf_q     (ovf_q),
    .ien_q     (ien_q),
    .irq       (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_STS:  bus_rdata[STS_OVF] = ovf_q;
        SEL_IEN:  bus_rdata[IEN_W-1:0] = ien_q;
        SEL_CTL: begin
          bus_rdata[CTL_RUN]  = run_q;
          bus_rdata[CTL_AUTO] = auto_q;
        end
        SEL_CNT:  bus_rdata = cnt_q;
        SEL_LOAD: bus_rdata = load_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/artimer_checker.sv
`timescale 1ns/1ps
module artimer_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              wrap,
  input logic              wr_cnt,
  input logic              wr_ctl,
  input logic              wr_sts,
  input logic              wr_ien,
  input logic              run_q,
  input logic              auto_q,
  input logic              ovf_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] load_q
);
  import artimer_pkg::*;

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (cnt_q == '0 && !run_q && !irq && !ovf_q));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !wr_cnt && !(&cnt_q)) |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run_q && tick) && !wr_cnt) |=> $stable(cnt_q));

  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && auto_q) |=> cnt_q == $past(load_q));

  a_r4_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !auto_q && !wr_ctl) |=> (!run_q && cnt_q == '0));

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_q);

  a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && bus_wdata[STS_OVF] && !wrap) |=> !ovf_q);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(wr_sts && bus_wdata[STS_OVF])) |=> ovf_q);

  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wrap) || $past(wr_ien)));

  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(bus_wdata));

  a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

bind artimer_top artimer_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .wrap      (wrap),
  .wr_cnt    (wr_cnt),
  .wr_ctl    (wr_ctl),
  .wr_sts    (wr_sts),
  .wr_ien    (wr_ien),
  .run_q     (run_q),
  .auto_q    (auto_q),
  .ovf_q     (ovf_q),
  .cnt_q     (cnt_q),
  .load_q    (load_q)
);

// File: tb/artimer_top_bench.sv
`timescale 1ns/1ps
module artimer_top_bench;
  localparam int WD_LIMIT = 20000;
  localparam int R_STS = 1, R_IEN = 2, R_CTL = 3, R_CNT = 4, R_LOAD = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;

  int    n_checks = 0;
  int    n_fail = 0;
  int    cycles = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  artimer_top #(.LAYOUT(0)) u_artimer_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq(irq_a)
  );

  artimer_top #(.LAYOUT(1)) u_artimer_top_alt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq(irq_b)
  );

  // R9 offset tables, written independently per layout
  function automatic logic [7:0] offset_of(int lay, int r);
    logic [7:0] hi [5] = '{8'h28, 8'h2C, 8'h38, 8'h3C, 8'h40};
    logic [7:0] lo [5] = '{8'h18, 8'h1C, 8'h24, 8'h28, 8'h2C};
    return (lay == 0) ? hi[r-1] : lo[r-1];
  endfunction

  function automatic int which_reg(int lay, logic [7:0] a);
    for (int r = 1; r <= 5; r++) if (offset_of(lay, r) == a) return r;
    return 0;
  endfunction

  // behavioural reference model, one slot per layout
  logic [31:0] m_cnt [2];
  logic [31:0] m_load [2];
  logic        m_run [2];
  logic        m_auto [2];
  logic        m_ovf [2];
  logic [2:0]  m_ien [2];

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_cnt[i] = 0; m_load[i] = 0; m_run[i] = 0; m_auto[i] = 0;
        m_ovf[i] = 0; m_ien[i] = 0;
      end else begin
        int          r;
        logic        ticking, overflow;
        logic [31:0] old_load;
        r        = bus_wr ? which_reg(i, bus_addr) : 0;
        ticking  = tick && m_run[i];
        overflow = ticking && (m_cnt[i] == 32'hFFFF_FFFF) && (r != R_CNT);
        old_load = m_load[i];
        if (r == R_CNT) m_cnt[i] = bus_wdata;
        else if (ticking) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) m_cnt[i] = m_auto[i] ? old_load : 0;
          else m_cnt[i] = m_cnt[i] + 1;
        end
        if (r == R_CTL) begin
          m_run[i] = bus_wdata[0];
          m_auto[i] = bus_wdata[1];
        end else if (overflow && !m_auto[i]) m_run[i] = 0;
        if (overflow) m_ovf[i] = 1;
        else if (r == R_STS && bus_wdata[1]) m_ovf[i] = 0;
        if (r == R_IEN) m_ien[i] = bus_wdata[2:0];
        if (r == R_LOAD) m_load[i] = bus_wdata;
      end
    end
  end

  function automatic logic [31:0] model_read(int i);
    if (!bus_rd) return 0;
    case (which_reg(i, bus_addr))
      R_STS:  return {30'd0, m_ovf[i], 1'b0};
      R_IEN:  return {29'd0, m_ien[i]};
      R_CTL:  return {30'd0, m_auto[i], m_run[i]};
      R_CNT:  return m_cnt[i];
      R_LOAD: return m_load[i];
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model for both copies
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk({cur_req, " model rdata L0"}, rdata_a, model_read(0));
      chk({cur_req, " model rdata L1"}, rdata_b, model_read(1));
      chk({cur_req, " model irq L0 R6"}, {31'd0, irq_a}, {31'd0, m_ovf[0] & m_ien[0][1]});
      chk({cur_req, " model irq L1 R6"}, {31'd0, irq_b}, {31'd0, m_ovf[1] & m_ien[1][1]});
    end
  end

  task automatic wr(int lay, int r, logic [31:0] d, logic with_tick = 1'b0);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = offset_of(lay, r); bus_wdata = d; tick = with_tick;
    @(negedge clk); #1;
    bus_wr = 0; tick = 0;
  endtask

  task automatic wr_raw(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd_raw(logic [7:0] a, int lay, output logic [31:0] v);
    @(negedge clk); #1;
    bus_rd = 1; bus_addr = a;
    #2 v = (lay == 0) ? rdata_a : rdata_b;
    @(negedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic expect_reg(string req, int lay, int r, logic [31:0] exp);
    logic [31:0] v;
    rd_raw(offset_of(lay, r), lay, v);
    chk(req, v, exp);
  endtask

  task automatic pulse(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1 tick = 1;
      @(negedge clk); #1 tick = 0;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    wait (cycles >= WD_LIMIT);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got %0d cycles expected < %0d", cycles, WD_LIMIT);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;

    cur_req = "R1";
    expect_reg("R1 counter", 0, R_CNT, 0);
    expect_reg("R1 control", 0, R_CTL, 0);
    expect_reg("R1 enable", 0, R_IEN, 0);
    expect_reg("R1 status", 0, R_STS, 0);
    expect_reg("R1 preload", 0, R_LOAD, 0);
    chk("R1 irq", {31'd0, irq_a}, 0);
    pulse(2);
    expect_reg("R1 stays stopped", 0, R_CNT, 0);

    cur_req = "R2";
    wr(0, R_CNT, 5);
    wr(0, R_CTL, 1);
    pulse(3);
    expect_reg("R2 three ticks", 0, R_CNT, 8);
    repeat (3) @(negedge clk);
    expect_reg("R2 no tick holds", 0, R_CNT, 8);
    wr(0, R_CTL, 0);
    pulse(2);
    expect_reg("R2 run clear holds", 0, R_CNT, 8);

    cur_req = "R8";
    wr(0, R_LOAD, 32'hFFFF_FFFC);
    wr(0, R_CNT, 32'hFFFF_FFFC);
    wr(0, R_IEN, 2);
    wr(0, R_CTL, 3);
    pulse(3);
    expect_reg("R8 no flag after N-1", 0, R_STS, 0);
    pulse(1);
    expect_reg("R8 flag after N", 0, R_STS, 2);
    expect_reg("R3 reloaded", 0, R_CNT, 32'hFFFF_FFFC);
    expect_reg("R3 run kept", 0, R_CTL, 3);
    chk("R6 irq raised", {31'd0, irq_a}, 1);

    cur_req = "R5";
    wr(0, R_STS, 0);
    expect_reg("R5 write zero keeps", 0, R_STS, 2);
    wr(0, R_STS, 2);
    expect_reg("R5 write one clears", 0, R_STS, 0);
    chk("R6 irq drops", {31'd0, irq_a}, 0);
    cur_req = "R8";
    pulse(4);
    expect_reg("R8 second period", 0, R_STS, 2);

    cur_req = "R6";
    wr(0, R_IEN, 5);
    chk("R6 other enables silent", {31'd0, irq_a}, 0);
    expect_reg("R10 enable readback", 0, R_IEN, 5);
    wr(0, R_IEN, 2);
    chk("R6 overflow enable", {31'd0, irq_a}, 1);
    wr(0, R_STS, 2);

    cur_req = "R5";
    wr(0, R_CNT, 32'hFFFF_FFFF);
    wr(0, R_STS, 2, 1'b1);
    expect_reg("R5 set beats clear", 0, R_STS, 2);

    cur_req = "R3";
    wr(0, R_LOAD, 0);
    wr(0, R_STS, 2);
    wr(0, R_CNT, 32'hFFFF_FFFE);
    pulse(2);
    expect_reg("R3 free-run wrap", 0, R_CNT, 0);
    expect_reg("R3 free-run status", 0, R_STS, 2);
    pulse(1);
    expect_reg("R3 keeps counting", 0, R_CNT, 1);

    cur_req = "R4";
    wr(0, R_STS, 2);
    wr(0, R_CTL, 1);
    wr(0, R_CNT, 32'hFFFF_FFFE);
    pulse(2);
    expect_reg("R4 wraps to zero", 0, R_CNT, 0);
    expect_reg("R4 run cleared", 0, R_CTL, 0);
    expect_reg("R4 flag set", 0, R_STS, 2);
    pulse(3);
    expect_reg("R4 stays stopped", 0, R_CNT, 0);

    cur_req = "R7";
    wr(0, R_STS, 2);
    wr(0, R_CTL, 1);
    wr(0, R_CNT, 100, 1'b1);
    expect_reg("R7 write beats tick", 0, R_CNT, 100);
    wr(0, R_CNT, 32'hFFFF_FFFF);
    wr(0, R_CNT, 7, 1'b1);
    expect_reg("R7 value", 0, R_CNT, 7);
    expect_reg("R7 no overflow", 0, R_STS, 0);
    expect_reg("R7 run kept", 0, R_CTL, 1);

    cur_req = "R9";
    wr_raw(8'h30, 32'hFFFF_FFFF);
    begin
      logic [31:0] v;
      rd_raw(8'h30, 0, v);
      chk("R9 unmapped reads zero", v, 0);
    end
    expect_reg("R9 unmapped write ignored", 0, R_CNT, 7);
    expect_reg("R9 preload untouched", 0, R_LOAD, 0);
    cur_req = "R10";
    @(negedge clk); #1 bus_addr = offset_of(0, R_CNT); bus_rd = 0;
    #2 chk("R10 idle read zero", rdata_a, 0);

    cur_req = "R9";
    wr(1, R_CTL, 0);
    wr(1, R_LOAD, 32'hFFFF_FFFE);
    wr(1, R_CNT, 32'hFFFF_FFFE);
    wr(1, R_IEN, 2);
    wr(1, R_STS, 2);
    wr(1, R_CTL, 3);
    pulse(2);
    expect_reg("R9 alt layout reload", 1, R_CNT, 32'hFFFF_FFFE);
    expect_reg("R9 alt layout status", 1, R_STS, 2);
    chk("R9 alt layout irq", {31'd0, irq_b}, 1);
    begin
      logic [31:0] v;
      rd_raw(8'h38, 1, v);
      chk("R9 other layout offset unmapped", v, 0);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule